// File: doc/BRIEF.md
# Vector Fixed-Point Saturating, Averaging and Fractional-Multiply Unit

This block applies one fixed-point operation to every element of two packed source vectors at once. The vector is `VLEN` bits wide and is split into 8-, 16- or 32-bit elements according to an element-width select. The unit supports saturating add and subtract, in signed and unsigned forms. It also supports averaging add and subtract, in signed and unsigned forms, and a signed fractional multiply in which every operand and the result carry width-minus-one fraction bits. A 2-bit rounding-mode input sets how the discarded low bits of averaging and multiply results are rounded.

Results are registered, so they appear one clock after a request and `out_valid` marks them. A status flag records any element that clamped. The flag keeps its value across later requests until the surrounding logic pulses the clear input. The unit has no masking and no tail handling: every element of the vector is written.

Top module: `fxp_vec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `sat_flag` are all zero after that edge.
- R2: A request sampled with `in_valid` high at a rising edge has its result on `result` with `out_valid` high after that same edge. `out_valid` is low after an edge with no request.
- R3: `sew` selects the element width: 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits. Element i occupies bits [i*EW +: EW] of each vector. `sew` = 3 is reserved: it yields an all-zero result and never sets the flag.
- R4: Unsigned saturating add (`op` = 0) clamps to all ones on carry-out. Unsigned saturating subtract (`op` = 2) clamps to zero on borrow.
- R5: Signed saturating add (`op` = 1) and signed saturating subtract (`op` = 3) clamp to the largest positive or most negative element value when the exact result is out of range.
- R6: The averaging operations are unsigned add (`op` = 4), signed add (`op` = 5), unsigned subtract (`op` = 6) and signed subtract (`op` = 7). Each forms the exact sum or difference, shifts it right by one bit, and rounds the dropped bit.
- R7: `rnd_mode` sets the increment added after the shift. 0 rounds to nearest with ties up. 1 rounds to nearest with ties to even. 2 truncates. 3 rounds to odd, which forces the LSB to one when any dropped bit is set.
- R8: The fractional multiply (`op` = 8) forms the signed double-width product, shifts it right by EW-1 bits, and rounds it per R7.
- R9: A fractional multiply of the most negative value by itself yields the largest positive value and raises the flag. No other operand pair saturates.
- R10: `sat_flag` goes high after any edge at which a request had at least one clamping element. It stays high while no clear is applied.
- R11: `sat_clr` clears `sat_flag` at the next edge. If the same edge samples a request that saturates, the flag ends up set.
- R12: Operation codes 9 to 15 yield an all-zero result and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code (see R4-R9, R12) |
| sew | input | 2 | Element width select (see R3) |
| rnd_mode | input | 2 | Rounding mode (see R7) |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector (subtrahend for subtract) |
| sat_clr | input | 1 | Clear for the saturation flag |
| out_valid | output | 1 | Result valid |
| result | output | VLEN | Registered result vector |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
All arithmetic is combinational ahead of one output register, so a wrong lane slice, rounding term or clamp is visible on `result` in the cycle right after the request. The bench sweeps all three widths, every rounding mode and random operands to reach each lane. Flag faults show up more slowly. A flag that fails to hold, or one that ignores the clear, appears only when an idle cycle or a clear follows a saturating request. For this reason the bench places non-saturating requests and clear pulses between saturating ones and compares the flag after every cycle.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    typedef enum logic [3:0] {
        OP_SADDU = 4'd0,
        OP_SADD  = 4'd1,
        OP_SSUBU = 4'd2,
        OP_SSUB  = 4'd3,
        OP_AADDU = 4'd4,
        OP_AADD  = 4'd5,
        OP_ASUBU = 4'd6,
        OP_ASUB  = 4'd7,
        OP_FMUL  = 4'd8
    } fxp_op_e;

    typedef enum logic [1:0] {
        RM_NEAR_UP   = 2'd0,
        RM_NEAR_EVEN = 2'd1,
        RM_DOWN      = 2'd2,
        RM_ODD       = 2'd3
    } fxp_rm_e;

    typedef struct packed {
        logic legal;
        logic is_signed;
        logic is_sub;
        logic is_avg;
        logic is_mul;
    } fxp_ctl_t;

    localparam int NUM_SEW  = 3;
    localparam int MIN_EW   = 8;

    function automatic fxp_ctl_t fxp_decode(input logic [3:0] code);
        fxp_ctl_t c;
        c = '0;
        c.legal     = (code <= OP_FMUL);
        c.is_mul    = (code == OP_FMUL);
        c.is_avg    = code[2] & ~code[3];
        c.is_sub    = code[1] & ~code[3];
        c.is_signed = code[0] | code[3];
        return c;
    endfunction

    // Increment applied after dropping low bits: lsb is the kept LSB,
    // half the first dropped bit, rest the OR of the dropped bits below it.
    function automatic logic fxp_round_inc(input fxp_rm_e rm, input logic lsb,
                                           input logic half, input logic rest);
        logic inc;
        case (rm)
            RM_NEAR_UP:   inc = half;
            RM_NEAR_EVEN: inc = half & (rest | lsb);
            RM_DOWN:      inc = 1'b0;
            default:      inc = ~lsb & (half | rest);
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/fxp_lane.sv
module fxp_lane
    import fxp_pkg::*;
#(
    parameter int EW = 8
) (
    input  fxp_ctl_t        ctl,
    input  fxp_rm_e         rm,
    input  logic [EW-1:0]   a,
    input  logic [EW-1:0]   b,
    output logic [EW-1:0]   res,
    output logic            sat
);
    localparam int PW = 2 * EW;
    localparam logic [EW-1:0] UMAX = {EW{1'b1}};
    localparam logic [EW-1:0] SMAX = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] SMIN = {1'b1, {(EW-1){1'b0}}};

    logic [EW:0]   ext_a, ext_b, sum;
    logic [PW-1:0] prod;
    logic [EW-1:0] mul_q;
    logic          inc_avg, inc_mul, mul_ovf;

    always_comb begin
        ext_a   = ctl.is_signed ? {a[EW-1], a} : {1'b0, a};
        ext_b   = ctl.is_signed ? {b[EW-1], b} : {1'b0, b};
        sum     = ctl.is_sub ? (ext_a - ext_b) : (ext_a + ext_b);
        prod    = $signed({{EW{a[EW-1]}}, a}) * $signed({{EW{b[EW-1]}}, b});
        mul_q   = prod[PW-2:EW-1];
        mul_ovf = prod[PW-1] ^ prod[PW-2];
        inc_avg = fxp_round_inc(rm, sum[1], sum[0], 1'b0);
        inc_mul = fxp_round_inc(rm, prod[EW-1], prod[EW-2], |prod[EW-3:0]);
    end

    always_comb begin
        res = '0;
        sat = 1'b0;
        if (!ctl.legal) begin
            res = '0;
        end else if (ctl.is_mul) begin
            if (mul_ovf) begin
                res = SMAX;
                sat = 1'b1;
            end else begin
                res = mul_q + {{(EW-1){1'b0}}, inc_mul};
            end
        end else if (ctl.is_avg) begin
            res = sum[EW:1] + {{(EW-1){1'b0}}, inc_avg};
        end else if (!ctl.is_signed) begin
            if (sum[EW]) begin
                res = ctl.is_sub ? '0 : UMAX;
                sat = 1'b1;
            end else begin
                res = sum[EW-1:0];
            end
        end else begin
            if (sum[EW] != sum[EW-1]) begin
                res = sum[EW] ? SMIN : SMAX;
                sat = 1'b1;
            end else begin
                res = sum[EW-1:0];
            end
        end
    end

endmodule

// File: rtl/fxp_lane_array.sv
module fxp_lane_array
    import fxp_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int EW   = 8
) (
    input  fxp_ctl_t          ctl,
    input  fxp_rm_e           rm,
    input  logic [VLEN-1:0]   va,
    input  logic [VLEN-1:0]   vb,
    output logic [VLEN-1:0]   vres,
    output logic              sat_any
);
    localparam int NL = VLEN / EW;

    logic [NL-1:0] lane_sat;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        fxp_lane #(.EW(EW)) u_lane (
            .ctl (ctl),
            .rm  (rm),
            .a   (va[i*EW +: EW]),
            .b   (vb[i*EW +: EW]),
            .res (vres[i*EW +: EW]),
            .sat (lane_sat[i])
        );
    end

    assign sat_any = |lane_sat;

endmodule

// File: rtl/fxp_sat_sticky.sv
module fxp_sat_sticky (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= (flag & ~clr) | set;
    end
endmodule

// File: rtl/fxp_vec_unit.sv
module fxp_vec_unit
    import fxp_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [3:0]      op,
    input  logic [1:0]      sew,
    input  logic [1:0]      rnd_mode,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    input  logic            sat_clr,
    output logic            out_valid,
    output logic [VLEN-1:0] result,
    output logic            sat_flag
);
    fxp_ctl_t        ctl;
    fxp_rm_e         rm;
    logic [VLEN-1:0] res_w [NUM_SEW];
    logic [NUM_SEW-1:0] sat_w;
    logic [VLEN-1:0] sel_res;
    logic            sel_sat;

    assign ctl = fxp_decode(op);
    assign rm  = fxp_rm_e'(rnd_mode);

    for (genvar g = 0; g < NUM_SEW; g++) begin : g_width
        fxp_lane_array #(.VLEN(VLEN), .EW(MIN_EW << g)) u_arr (
            .ctl     (ctl),
            .rm      (rm),
            .va      (src_a),
            .vb      (src_b),
            .vres    (res_w[g]),
            .sat_any (sat_w[g])
        );
    end

    always_comb begin
        case (sew)
            2'd0:    begin sel_res = res_w[0]; sel_sat = sat_w[0]; end
            2'd1:    begin sel_res = res_w[1]; sel_sat = sat_w[1]; end
            2'd2:    begin sel_res = res_w[2]; sel_sat = sat_w[2]; end
            default: begin sel_res = '0;       sel_sat = 1'b0;     end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= sel_res;
        end
    end

    fxp_sat_sticky u_sticky (
        .clk  (clk),
        .rst  (rst),
        .clr  (sat_clr),
        .set  (in_valid & sel_sat),
        .flag (sat_flag)
    );

endmodule

// File: rtl/fxp_vec_checker.sv
module fxp_vec_checker #(
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [3:0]      op,
    input logic [1:0]      sew,
    input logic [1:0]      rnd_mode,
    input logic [VLEN-1:0] src_a,
    input logic [VLEN-1:0] src_b,
    input logic            sat_clr,
    input logic            out_valid,
    input logic [VLEN-1:0] result,
    input logic            sat_flag
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && !sat_flag && result == '0));  // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);  // R2

    AST_RESERVED_SEW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sew == 2'd3 && !sat_clr) |=> (result == '0 && sat_flag == $past(sat_flag)));  // R3

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clr) |=> sat_flag);  // R10

    AST_FLAG_RISES_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> out_valid);  // R10

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (sat_clr && !in_valid) |=> !sat_flag);  // R11

    AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > 4'd8 && !sat_clr) |=> (result == '0 && sat_flag == $past(sat_flag)));  // R12

endmodule

bind fxp_vec_unit fxp_vec_checker #(.VLEN(VLEN)) u_fxp_vec_checker (.*);

// File: tb/test_fxp_vec_unit.sv
module test_fxp_vec_unit;

    localparam int VLEN = 128;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [3:0]      op;
    logic [1:0]      sew;
    logic [1:0]      rnd_mode;
    logic [VLEN-1:0] src_a, src_b;
    logic            sat_clr;
    logic            out_valid;
    logic [VLEN-1:0] result;
    logic            sat_flag;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  flag_m   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    fxp_vec_unit #(.VLEN(VLEN)) i_fxp_vec_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .sew(sew),
        .rnd_mode(rnd_mode), .src_a(src_a), .src_b(src_b), .sat_clr(sat_clr),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    task automatic check_vec(string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic longint round_shift(longint v, int d, int rm);
        longint q, rem, half, low;
        bit inc;
        q    = v >>> d;
        rem  = v - (q <<< d);
        half = (rem >> (d - 1)) & 64'd1;
        low  = rem & ((longint'(1) << (d - 1)) - 1);
        case (rm)
            0: inc = (half != 0);
            1: inc = (half != 0) && (low != 0 || (q & 1) != 0);
            2: inc = 1'b0;
            default: inc = ((q & 1) == 0) && (rem != 0);
        endcase
        return q + longint'(inc);
    endfunction

    function automatic longint model_elem(int opc, int ew, int rm,
                                          longint ua, longint ub, output bit s);
        longint a, b, v, hi, lo, r, mask;
        bit sgn;
        s    = 1'b0;
        mask = (longint'(1) << ew) - 1;
        sgn  = (opc == 1 || opc == 3 || opc == 5 || opc == 7 || opc == 8);
        a    = (sgn && ua[ew-1]) ? ua - (longint'(1) << ew) : ua;
        b    = (sgn && ub[ew-1]) ? ub - (longint'(1) << ew) : ub;
        hi   = sgn ? (longint'(1) << (ew - 1)) - 1 : mask;
        lo   = sgn ? -(longint'(1) << (ew - 1)) : 0;
        case (opc)
            0, 1, 2, 3: begin
                v = (opc >= 2) ? a - b : a + b;
                r = v;
                if (v > hi) begin r = hi; s = 1'b1; end
                if (v < lo) begin r = lo; s = 1'b1; end
            end
            4, 5, 6, 7: begin
                v = (opc >= 6) ? a - b : a + b;
                r = round_shift(v, 1, rm);
            end
            8: begin
                r = round_shift(a * b, ew - 1, rm);
                if (r > hi) begin r = hi; s = 1'b1; end
            end
            default: r = 0;
        endcase
        return r & mask;
    endfunction

    // Drive one request, sample one cycle later, compare result and flag.
    task automatic run_op(string req, int opc, int sewc, int rm,
                          logic [VLEN-1:0] a, logic [VLEN-1:0] b, bit clr = 1'b0);
        logic [VLEN-1:0] exp_v, sa, sb;
        bit any_sat, s;
        int ew;
        longint r;
        exp_v   = '0;
        any_sat = 1'b0;
        if (sewc < 3) begin
            ew = 8 << sewc;
            for (int i = 0; i < VLEN / ew; i++) begin
                sa = a >> (i * ew);
                sb = b >> (i * ew);
                r = model_elem(opc, ew, rm,
                               longint'(sa[31:0]) & ((longint'(1) << ew) - 1),
                               longint'(sb[31:0]) & ((longint'(1) << ew) - 1), s);
                exp_v   = exp_v | (VLEN'(r) << (i * ew));
                any_sat = any_sat | s;
            end
        end
        flag_m = (flag_m & ~clr) | any_sat;
        @(negedge clk);
        in_valid = 1'b1; op = 4'(opc); sew = 2'(sewc); rnd_mode = 2'(rm);
        src_a = a; src_b = b; sat_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; sat_clr = 1'b0;
        check_bit({req, " out_valid"}, out_valid, 1'b1);
        check_vec({req, " result"}, result, exp_v);
        check_bit({req, " sat_flag"}, sat_flag, flag_m);
    endtask

    task automatic idle_cycle(string req, bit clr);
        flag_m = flag_m & ~clr;
        @(negedge clk);
        sat_clr = clr;
        @(negedge clk);
        sat_clr = 1'b0;
        check_bit({req, " idle out_valid"}, out_valid, 1'b0);
        check_bit({req, " idle sat_flag"}, sat_flag, flag_m);
    endtask

    function automatic logic [VLEN-1:0] splat(int ew, longint v);
        logic [VLEN-1:0] x = '0;
        for (int i = 0; i < VLEN / ew; i++) x = x | (VLEN'(v & ((longint'(1) << ew) - 1)) << (i * ew));
        return x;
    endfunction

    function automatic logic [VLEN-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic t_reset();  // R1
        rst = 1'b1; in_valid = 1'b0; op = '0; sew = '0; rnd_mode = '0;
        src_a = '0; src_b = '0; sat_clr = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R1 out_valid", out_valid, 1'b0);
        check_vec("R1 result", result, '0);
        check_bit("R1 sat_flag", sat_flag, 1'b0);
        rst = 1'b0;
        flag_m = 1'b0;
    endtask

    task automatic t_latency();  // R2
        run_op("R2 latency", 0, 0, 0, splat(8, 3), splat(8, 4));
        idle_cycle("R2", 1'b0);
    endtask

    task automatic t_unsigned_sat();  // R4
        run_op("R4 add carry", 0, 0, 0, splat(8, 8'hF0), splat(8, 8'h20));
        idle_cycle("R4", 1'b1);
        run_op("R4 sub borrow", 2, 1, 0, splat(16, 5), splat(16, 9));
        idle_cycle("R4", 1'b1);
        run_op("R4 no clamp", 0, 2, 0, splat(32, 32'h7FFF_FFFF), splat(32, 1));
    endtask

    task automatic t_signed_sat();  // R5
        run_op("R5 add pos ovf", 1, 1, 0, splat(16, 16'h7FF0), splat(16, 16'h0020));
        idle_cycle("R5", 1'b1);
        run_op("R5 sub neg ovf", 3, 0, 0, splat(8, 8'h80), splat(8, 8'h01));
        idle_cycle("R5", 1'b1);
        run_op("R5 sub in range", 3, 2, 0, splat(32, -5), splat(32, 7));
    endtask

    task automatic t_average();  // R6 R7
        for (int rm = 0; rm < 4; rm++) begin
            run_op("R6 R7 avg add u odd", 4, 0, rm, splat(8, 1), splat(8, 2));
            run_op("R6 R7 avg add u tie", 4, 1, rm, splat(16, 1), splat(16, 0));
            run_op("R6 R7 avg add s", 5, 2, rm, splat(32, -3), splat(32, 0));
            run_op("R6 R7 avg sub u", 6, 0, rm, splat(8, 8'h10), splat(8, 8'hFF));
            run_op("R6 R7 avg sub s", 7, 1, rm, splat(16, 16'h8000), splat(16, 16'h7FFF));
            run_op("R6 R7 avg max", 4, 0, rm, splat(8, 8'hFF), splat(8, 8'hFE));
        end
    endtask

    task automatic t_multiply();  // R8 R7
        for (int rm = 0; rm < 4; rm++) begin
            run_op("R8 R7 mul half", 8, 0, rm, splat(8, 8'h40), splat(8, 8'h41));
            run_op("R8 R7 mul neg", 8, 1, rm, splat(16, 16'hC001), splat(16, 16'h3003));
            run_op("R8 R7 mul 32", 8, 2, rm, splat(32, 32'h8000_0001), splat(32, 32'h8000_0000));
        end
    endtask

    task automatic t_minmin();  // R9
        idle_cycle("R9", 1'b1);
        run_op("R9 min*min 8", 8, 0, 0, splat(8, 8'h80), splat(8, 8'h80));
        idle_cycle("R9", 1'b1);
        run_op("R9 min*min 32", 8, 2, 2, splat(32, 32'h8000_0000), splat(32, 32'h8000_0000));
        idle_cycle("R9", 1'b1);
        run_op("R9 min*(min+1)", 8, 1, 3, splat(16, 16'h8000), splat(16, 16'h8001));
    endtask

    task automatic t_sticky();  // R10 R11
        idle_cycle("R11 clear", 1'b1);
        run_op("R10 one lane sat", 0, 0, 0, {8'hFF, 120'h0}, {8'h01, 120'h0});
        run_op("R10 quiet op", 0, 0, 0, splat(8, 1), splat(8, 1));
        idle_cycle("R10 hold", 1'b0);
        idle_cycle("R11 clear", 1'b1);
        run_op("R11 clear plus sat", 1, 0, 0, splat(8, 8'h7F), splat(8, 8'h7F), 1'b1);
        run_op("R11 clear plus quiet", 1, 0, 0, splat(8, 1), splat(8, 1), 1'b1);
    endtask

    task automatic t_reserved();  // R3 R12
        run_op("R10 preset", 0, 0, 0, splat(8, 8'hFF), splat(8, 8'hFF));
        run_op("R3 reserved sew", 0, 3, 0, splat(8, 8'hFF), splat(8, 8'hFF));
        idle_cycle("R3", 1'b1);
        run_op("R3 reserved sew quiet", 8, 3, 0, splat(8, 8'h80), splat(8, 8'h80));
        for (int c = 9; c < 16; c++)
            run_op("R12 bad op", c, c % 3, 0, splat(8, 8'h80), splat(8, 8'h80));
    endtask

    task automatic t_random();  // R3 R4 R5 R6 R7 R8
        for (int k = 0; k < 300; k++) begin
            run_op("R3 random", int'($urandom % 9), int'($urandom % 3), int'($urandom % 4),
                   rnd_vec(), rnd_vec(), bit'($urandom % 5 == 0));
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_unsigned_sat();
        t_signed_sat();
        t_average();
        t_multiply();
        t_minmin();
        t_sticky();
        t_reserved();
        t_random();
        summary();
    end

endmodule